// File: doc/BRIEF.md
# Event Selector Latch with Interrupt Pulse

This block collects platform events for a hardware-reduced system and hands them to host software through one memory-mapped word. Each event source drives a request bit. Every cycle, the request vector is ORed into a 32-bit pending-event word. In the cycle after any request, the block raises a one-cycle, active-high interrupt pulse. The memory-hotplug source uses bit 0, so its value is 0x1.

The host reaches the word through a simple register bus. An access has a setup phase (select high, enable low) and then an access phase (select and enable both high). The block always completes the access phase in one cycle. A full-word read at offset 0 returns the pending bits and empties the word in the same access, so the interrupt handler learns which events fired by reading once. Writes are accepted and discarded. Accesses narrower than a word are rejected with an error.

Top module: `evt_sel_latch`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the pending word is cleared to 0x0 and `irq` is held low, whatever the event inputs do.
- R2: The pending word is the bitwise OR of every request bit seen since the last clearing read, so several events can be pending together.
- R3: A full-word read (`acc_size` = 2'b10) at `paddr` = 0 returns the pending word on `prdata` with `pslverr` = 0, and leaves the word at 0x0 after that access.
- R4: If a clearing read and a nonzero request fall in the same cycle, the read returns the old value and the word then holds exactly the new request bits.
- R5: A write of any data at any offset changes nothing. A full-word write completes with `pslverr` = 0.
- R6: A read at any `paddr` other than 0 returns 0x0 and does not clear the pending word.
- R7: An access with `acc_size` other than 2'b10 (2'b00 = 1 byte, 2'b01 = 2 bytes) completes with `pslverr` = 1 and `prdata` = 0x0, and it does not clear the pending word.
- R8: `irq` is high for exactly the one cycle after each cycle that has a nonzero request. Requests in consecutive cycles keep it high for one cycle each, and it drops in the first cycle after a cycle with no request.
- R9: Bit ordering is little-endian and positional: request bit i appears as `prdata` bit i, so a memory-hotplug event (bit 0) reads as 0x00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_req | input | SEL_W (32) | Event request bits, one per source, sampled each cycle |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte offset into the window |
| acc_size | input | 2 | Access size: 0 = byte, 1 = halfword, 2 = word |
| pwdata | input | SEL_W (32) | Write data (discarded) |
| prdata | output | SEL_W (32) | Read data |
| pready | output | 1 | Always 1; every access completes in one cycle |
| pslverr | output | 1 | Error response for narrow accesses |
| irq | output | 1 | One-cycle active-high event interrupt |

## Verification
The sharpest corner is a clearing read that lands in the same cycle as a new event. A design that clears with priority over the request would silently lose that event, and the follow-up read would return zero instead of the new bit. The bench also reads at a nonzero offset and with narrow sizes, then reads again at offset 0. A design that decodes the address loosely or ignores the access size would empty the word early, and the later read would come back zero. Writes of all-ones are issued and followed by a read, which shows whether a write leaked into the word. Single and back-to-back event cycles are used to measure the pulse width, which exposes a level that sticks or a pulse that merges.

// File: rtl/evt_sel_latch.sv
module evt_sel_latch #(
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  evt_req,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [1:0]        acc_size,
  input  logic [SEL_W-1:0]  pwdata,
  output logic [SEL_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq
);
  localparam logic [1:0] SZ_WORD = 2'd2;

  logic [SEL_W-1:0] sel_q;
  logic access, size_ok, at_sel, rd_hit;
  logic unused_wdata;

  assign access  = psel & penable;
  assign size_ok = (acc_size == SZ_WORD);
  assign at_sel  = (paddr == '0);
  assign rd_hit  = access & ~pwrite & size_ok & at_sel;

  assign pready  = 1'b1;
  assign pslverr = access & ~size_ok;
  assign prdata  = rd_hit ? sel_q : '0;
  assign unused_wdata = ^pwdata;

  // read clears, but same-cycle requests are kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      irq   <= 1'b0;
    end else begin
      sel_q <= (rd_hit ? '0 : sel_q) | evt_req;
      irq   <= |evt_req;
    end
  end

  p_accum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> ((sel_q & $past(sel_q)) == $past(sel_q)) &&
                ((sel_q & $past(evt_req)) == $past(evt_req)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> sel_q == $past(evt_req));

  p_keep_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && evt_req != '0) |=> sel_q != '0);

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (access && pwrite && evt_req == '0) |=> $stable(sel_q));

  p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !pwrite && paddr != '0) |-> prdata == '0);

  p_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (access && acc_size != SZ_WORD) |-> pslverr && prdata == '0);

  p_narrow_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (access && acc_size != SZ_WORD) |=> (sel_q & $past(sel_q)) == $past(sel_q));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_req != '0) |=> irq);

  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(evt_req) != '0);
endmodule

// File: tb/tb_evt_sel_latch.sv
module tb_evt_sel_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_req = '0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [1:0]  acc_size = 2'd2;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  evt_sel_latch dut (.clk(clk), .rst_n(rst_n), .evt_req(evt_req), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .acc_size(acc_size),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // setup phase, access phase (ev applied, outputs sampled), idle
  task automatic bus(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input logic [31:0] ev,
                     output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; acc_size = sz; pwdata = wd;
    @(negedge clk);
    penable = 1'b1; evt_req = ev;
    #1; rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; evt_req = '0;
  endtask

  task automatic pulse_evt(input logic [31:0] ev);
    @(negedge clk); evt_req = ev;
    @(negedge clk); evt_req = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    @(negedge clk); evt_req = 32'h1;
    @(negedge clk); check("R1 irq in reset", {31'b0, irq}, 32'h0);
    evt_req = '0;
    @(negedge clk); rst_n = 1'b1;
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R1 word after reset", d, 32'h0);
  endtask

  task automatic t_accum;
    logic [31:0] d; logic e;
    pulse_evt(32'h1);
    pulse_evt(32'h4);
    pulse_evt(32'h8000_0000);
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R2 accumulated", d, 32'h8000_0005);
    check("R3 no error", {31'b0, e}, 32'h0);
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R3 cleared", d, 32'h0);
    pulse_evt(32'h1);
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R9 hotplug bit", d, 32'h1);
  endtask

  task automatic t_irq;
    @(negedge clk); evt_req = 32'h2;
    @(negedge clk); evt_req = '0;
    check("R8 pulse high", {31'b0, irq}, 32'h1);
    @(negedge clk); check("R8 pulse one cycle", {31'b0, irq}, 32'h0);
    evt_req = 32'h2;
    @(negedge clk); evt_req = 32'h4;
    check("R8 first of pair", {31'b0, irq}, 32'h1);
    @(negedge clk); evt_req = '0;
    check("R8 second of pair", {31'b0, irq}, 32'h1);
    @(negedge clk); check("R8 drop after pair", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] d; logic e;
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R3 drain", d, 32'h6);
    pulse_evt(32'h10);
    bus(1'b0, 12'h0, 2'd2, '0, 32'h20, d, e);
    check("R4 old value", d, 32'h10);
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R4 new bits kept", d, 32'h20);
  endtask

  task automatic t_write;
    logic [31:0] d; logic e;
    pulse_evt(32'h8);
    bus(1'b1, 12'h0, 2'd2, 32'hFFFF_FFFF, '0, d, e);
    check("R5 write no error", {31'b0, e}, 32'h0);
    bus(1'b1, 12'h0, 2'd2, 32'h0, '0, d, e);
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R5 write ignored", d, 32'h8);
  endtask

  task automatic t_offset;
    logic [31:0] d; logic e;
    pulse_evt(32'h40);
    bus(1'b0, 12'h4, 2'd2, '0, '0, d, e);
    check("R6 offset 4 zero", d, 32'h0);
    bus(1'b0, 12'h1, 2'd2, '0, '0, d, e);
    check("R6 offset 1 zero", d, 32'h0);
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R6 not cleared", d, 32'h40);
  endtask

  task automatic t_narrow;
    logic [31:0] d; logic e;
    pulse_evt(32'h300);
    bus(1'b0, 12'h0, 2'd0, '0, '0, d, e);
    check("R7 byte error", {31'b0, e}, 32'h1);
    check("R7 byte data", d, 32'h0);
    bus(1'b0, 12'h0, 2'd1, '0, '0, d, e);
    check("R7 half error", {31'b0, e}, 32'h1);
    bus(1'b0, 12'h0, 2'd2, '0, '0, d, e);
    check("R7 not cleared", d, 32'h300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_accum();
    t_irq();
    t_collision();
    t_write();
    t_offset();
    t_narrow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule